// File: doc/BRIEF.md
# Programmable Modulus Clock Divider

The block divides a fast input clock by an integer modulus anywhere from 8 to 511. It produces one registered divided output. The modulus is a 9-bit unsigned binary word, and the block samples it again once in every output period. Because of this, the ratio can change from one output cycle to the next without a glitch. A sequence generator, for example a delta-sigma stream, can drive the modulus to achieve fractional average division.

The high time of the divided output follows a fixed rule rather than half the period. From 16 upward, the high time is constant within each octave of the modulus. Below 16, it depends on the two low modulus bits.

A one-cycle strobe marks the last input cycle of each output period. The modulus is captured on the clock edge that ends that cycle. External control logic uses the strobe to present the next modulus.

Top module: `modulus_divider`

## Requirements
- R1: Each output period lasts exactly N input clock cycles, where N = sum of mod_i[i]·2^i (bit 0 least significant) and N is any value from 8 to 511.
- R2: The modulus is captured only on the rising edge that ends a cycle with bound_o high. Changes of mod_i at any other time have no effect on the running period.
- R3: A captured modulus below 8, including 0 (the value of an undriven word), is treated as 8.
- R4: For N from 8 to 11, div_o is high for N−4 cycles at the start of the period.
- R5: For N from 12 to 15, div_o is high for N−8 cycles at the start of the period.
- R6: For N from 16 to 511, div_o is high for 2^(k−1) cycles, where 2^k ≤ N < 2^(k+1). This gives exactly 50% duty when N is a power of two.
- R7: div_o is high in the first cycle of every period and then forms a single contiguous high pulse. It rises only at a period start.
- R8: bound_o is high for exactly one cycle per period, in the last cycle of the period. It is also high while reset is held, requesting the first modulus.
- R9: While rst_ni is low, div_o is low. The first period starts on the first rising edge after reset is released, using the modulus present on mod_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mod_i | input | 9 | Binary division modulus, bit 0 least significant |
| div_o | output | 1 | Registered divided output |
| bound_o | output | 1 | High in the last input cycle of each output period |

## Verification
The bench goes after the octave edges of the high-time rule: 8, 11, 12, 15, 16, 31, 32, 255, 256 and 511.
- A design that selected the octave from the wrong bit would give the wrong pulse width, off by a factor of two at these edges.
- A design that confused the two sub-16 branches would give widths four cycles off.

Moduli 0, 3 and 7 probe the clamp. Without it, the period would collapse, or the counter would wrap after 512 cycles.

Every period also gets a random modulus change in mid-period. A design that sampled mod_i continuously would then show a period length other than the captured one.

Back-to-back jumps between extreme ratios check that the new ratio takes effect exactly one period after it is presented, with no extra or missing cycle.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
  localparam int unsigned MOD_W   = 9;
  localparam int unsigned MIN_MOD = 8;
  localparam int unsigned POS_W   = $clog2(MOD_W);

  typedef logic [MOD_W-1:0] mod_t;

  typedef struct packed {
    mod_t n;
    mod_t w;
  } ratio_t;
endpackage

// File: rtl/mdiv_width_rule.sv
module mdiv_width_rule #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] n_i,
  output logic [W-1:0] w_o
);
  localparam int unsigned LW = $clog2(W);

  logic [LW-1:0] msb;
  logic [W-1:0]  oct_w;

  // highest set bit, priority from the top
  always_comb begin
    msb = '0;
    for (int i = 0; i < W; i++) begin
      if (n_i[i]) msb = LW'(i);
    end
  end

  always_comb begin
    oct_w = '0;
    for (int i = 1; i < W; i++) begin
      if (msb == LW'(i)) oct_w = W'(1) << (i - 1);
    end
  end

  // below 16: four plus the low two bits
  assign w_o = (msb >= LW'(4)) ? oct_w : W'(4 + {30'd0, n_i[1:0]});
endmodule

// File: rtl/mdiv_mod_latch.sv
module mdiv_mod_latch
  import mdiv_pkg::*;
#(
  parameter int unsigned W   = MOD_W,
  parameter int unsigned MIN = MIN_MOD
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] n_o,
  output logic [W-1:0] w_o
);
  localparam logic [W-1:0] MIN_V = W'(MIN);

  logic [W-1:0] n_clamp, w_new, w_rst;
  logic [W-1:0] n_q, w_q;

  assign n_clamp = (mod_i < MIN_V) ? MIN_V : mod_i;

  mdiv_width_rule #(.W(W)) u_rule_new (.n_i(n_clamp), .w_o(w_new));
  mdiv_width_rule #(.W(W)) u_rule_rst (.n_i(MIN_V),   .w_o(w_rst));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= MIN_V;
      w_q <= w_rst;
    end else if (load_i) begin
      n_q <= n_clamp;
      w_q <= w_new;
    end
  end

  assign n_o = n_q;
  assign w_o = w_q;
endmodule

// File: rtl/mdiv_period_cnt.sv
module mdiv_period_cnt #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] n_i,
  output logic         wrap_o,
  output logic [W-1:0] pos_o
);
  logic [W-1:0] pos_q;
  logic         first_q;

  assign wrap_o = first_q | (pos_q == n_i - W'(1));
  assign pos_o  = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      first_q <= 1'b1;
    end else begin
      first_q <= 1'b0;
      pos_q   <= wrap_o ? '0 : pos_q + W'(1);
    end
  end
endmodule

// File: rtl/mdiv_out_stage.sv
module mdiv_out_stage #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wrap_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] w_i,
  output logic         div_o
);
  logic div_q;

  // width is at least 4, so a new period always opens high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= 1'b0;
    else if (wrap_i) div_q <= 1'b1;
    else             div_q <= (pos_i + W'(1)) < w_i;
  end

  assign div_o = div_q;
endmodule

// File: rtl/modulus_divider.sv
module modulus_divider
  import mdiv_pkg::*;
#(
  parameter int unsigned W   = MOD_W,
  parameter int unsigned MIN = MIN_MOD
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] mod_i,
  output logic         div_o,
  output logic         bound_o
);
  logic         wrap;
  logic [W-1:0] pos, n_cur, w_cur;

  mdiv_period_cnt #(.W(W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .n_i   (n_cur),
    .wrap_o(wrap),
    .pos_o (pos)
  );

  mdiv_mod_latch #(.W(W), .MIN(MIN)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wrap),
    .mod_i (mod_i),
    .n_o   (n_cur),
    .w_o   (w_cur)
  );

  mdiv_out_stage #(.W(W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wrap_i(wrap),
    .pos_i (pos),
    .w_i   (w_cur),
    .div_o (div_o)
  );

  assign bound_o = wrap;
endmodule

// File: rtl/modulus_divider_chk.sv
module modulus_divider_chk #(
  parameter int unsigned W = 9
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] mod_i,
  input logic         div_o,
  input logic         bound_o
);
  function automatic logic [W-1:0] ref_width(logic [W-1:0] n);
    logic [W-1:0] r;
    r = W'(4) + W'(n[1:0]);
    for (int k = 4; k < W; k++) begin
      if (n >= (W'(1) << k)) r = W'(1) << (k - 1);
    end
    return r;
  endfunction

  logic [W-1:0] n_exp_q, cnt_q;
  logic         seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_exp_q <= W'(8);
      cnt_q   <= '0;
      seen_q  <= 1'b0;
    end else if (bound_o) begin
      n_exp_q <= (mod_i < W'(8)) ? W'(8) : mod_i;
      cnt_q   <= '0;
      seen_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  p_period_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && bound_o) |-> (cnt_q == n_exp_q - W'(1)));

  p_no_early_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && cnt_q != n_exp_q - W'(1)) |-> !bound_o);

  p_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (div_o == (cnt_q < ref_width(n_exp_q))));

  p_open_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_o |=> div_o);

  p_rise_at_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_o) |-> $past(bound_o));

  p_single_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_o |=> !bound_o);

  always_comb begin
    if (!rst_ni) p_reset_low_r9: assert (!div_o);
  end
endmodule

bind modulus_divider modulus_divider_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mod_i  (mod_i),
  .div_o  (div_o),
  .bound_o(bound_o)
);

// File: tb/modulus_divider_test.sv
module modulus_divider_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i  = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] mod_i  = 9'd0;
  logic       div_o, bound_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  modulus_divider uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mod_i  (mod_i),
    .div_o  (div_o),
    .bound_o(bound_o)
  );

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int exp_mod(int m);
    return (m < 8) ? 8 : m;
  endfunction

  function automatic int exp_width(int m);
    int n = exp_mod(m);
    int p = 1;
    if (n < 12) return n - 4;
    if (n < 16) return n - 8;
    while (p * 2 <= n) p = p * 2;
    return p / 2;
  endfunction

  function automatic string width_req(int m);
    int n = exp_mod(m);
    if (n < 12) return "R4";
    if (n < 16) return "R5";
    return "R6";
  endfunction

  // cur is already captured; nxt is presented at the boundary
  task automatic run_period(int cur, int nxt);
    int n = exp_mod(cur);
    int w = exp_width(cur);
    int hi = 0;
    int len = 0;
    int bad_shape = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk_i);
      if (div_o) hi++;
      if (div_o != (k < w)) bad_shape++;
      if (k == 2) mod_i = 9'($urandom);
      if (bound_o) begin
        len = k + 1;
        mod_i = 9'(nxt);
        break;
      end
    end
    check(len == n, "R1", len, n);
    check(len == n, "R2", len, n);
    if (cur < 8) check(len == 8, "R3", len, 8);
    check(hi == w, width_req(cur), hi, w);
    check(bad_shape == 0, "R7", bad_shape, 0);
    check(len == n, "R8", len, n);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    int vals[$];
    int unsigned seed;
    seed = $urandom(32'h1d5eed);
    vals = '{8, 9, 11, 12, 15, 16, 31, 32, 63, 64, 255, 256, 511, 8, 511, 0, 3, 7, 13, 128};
    for (int i = 0; i < 40; i++) begin
      if (i % 5 == 0) vals.push_back(int'($urandom % 20));
      else            vals.push_back(int'($urandom % 512));
    end

    mod_i = 9'(vals[0]);
    repeat (3) @(negedge clk_i);
    check(div_o == 1'b0, "R9", int'(div_o), 0);
    check(bound_o == 1'b1, "R8", int'(bound_o), 1);
    rst_ni = 1'b1;

    for (int i = 0; i < vals.size(); i++) begin
      run_period(vals[i], (i + 1 < vals.size()) ? vals[i + 1] : 8);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule